// File: doc/BRIEF.md
# DDR2 Power-Up Command Sequencer

This block plays back the DDR2 power-up command sequence from a small table of fourteen entries that software fills in before memory is brought up. Each entry holds a valid flag, a command code, a mode-register select, an address payload and a post-command wait measured in memory clocks. A single execute pulse walks the table from the lowest index to the highest. For each valid entry, the block puts that entry's command on the command/address outputs for one cycle. It then holds the bus at NOP for the programmed number of cycles before it moves on.

When the last wait has run out, the block reports completion. The enable bit for normal memory traffic can only be set once completion is reported, and a fresh execute clears that bit again. A calibration-done flag from the delay-line logic is handed straight through to a status output, so the same status view covers both conditions that software polls before sizing memory. While a run is in progress, table writes and further execute pulses are ignored.

Top module: `ddr2_init_seq`

## Requirements
- R1: A write with `wrEn` high stores `wrData` into entry `wrIdx`. The field layout of `wrData` is: bit 27 valid; bits 26:24 command (0 NOP, 1 precharge all, 2 refresh, 3 mode-register load); bits 23:22 register select (0 MR, 1 EMR, 2 EMR2, 3 EMR3); bits 21:8 address payload; bits 7:0 wait count. All entries reset to zero.
- R2: When `execReq` is sampled high while idle, `busy` rises at the next clock. The first valid entry is issued in that same next cycle.
- R3: Valid entries issue in ascending index order. Invalid entries are skipped and consume no cycles.
- R4: An entry with wait count N is followed by exactly N cycles without an issue, so the next issue comes N+1 cycles later. N = 0 lets the next entry issue in the very next cycle.
- R5: During an issue cycle, `cmdIssue` is high and `cmdOut`, `bankOut` and `addrOut` carry the entry's fields. In every other cycle, `cmdIssue` is low and all three outputs are zero (NOP).
- R6: `initDone` is low while `busy` is high. It rises W+2 cycles after the last issue, where W is the wait of the last entry. If no entry is valid, it rises 2 cycles after `execReq` is sampled.
- R7: `ctrlEnSet` sets `ctrlEnable` only while `initDone` is high; at any other time it is ignored. An accepted execute clears both `ctrlEnable` and `initDone`.
- R8: Table writes and `execReq` pulses that arrive while `busy` is high have no effect on the run or on the table.
- R9: `calDoneOut` follows `calDoneIn`.
- R10: After reset, `busy`, `initDone`, `ctrlEnable` and `cmdIssue` are low, and the command bus is at NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Table write strobe |
| wrIdx | input | 4 | Table entry index |
| wrData | input | 28 | Entry contents |
| execReq | input | 1 | Start pulse for a run |
| ctrlEnSet | input | 1 | Request to enable normal traffic |
| calDoneIn | input | 1 | Delay-line calibration finished |
| cmdIssue | output | 1 | High during a command cycle |
| cmdOut | output | 3 | Command code |
| bankOut | output | 2 | Mode-register select |
| addrOut | output | 14 | Address payload |
| busy | output | 1 | Run in progress |
| initDone | output | 1 | Run completed |
| ctrlEnable | output | 1 | Normal traffic enabled |
| calDoneOut | output | 1 | Calibration-done status |

## Verification
The scoreboard times every issued command to the cycle. A sequencer that spent a cycle on a skipped entry, or counted N-1 or N+1 wait cycles, would shift every later stamp and fail the gap check. A second program mixes invalid entries (including the first and the last) with zero waits, which exposes off-by-one errors in the search and back-to-back issue. In the middle of a run, the bench pulses execute, writes a not-yet-issued entry and requests enable. A design that restarted, took the write or enabled traffic early would show a repeated entry 0, a corrupted entry 13 or a high `ctrlEnable`. A run with every entry invalid checks that completion still arrives, and on time.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;
  localparam int NUM_ENTRIES = 14;
  localparam int WAIT_W      = 8;
  localparam int ADDR_W      = 14;
  localparam int BANK_W      = 2;
  localparam int CMD_W       = 3;
  localparam int IDX_W       = $clog2(NUM_ENTRIES);
  localparam int PTR_W       = $clog2(NUM_ENTRIES + 1);

  localparam logic [CMD_W-1:0] CMD_NOP = 3'd0;
  localparam logic [CMD_W-1:0] CMD_PRE = 3'd1;
  localparam logic [CMD_W-1:0] CMD_REF = 3'd2;
  localparam logic [CMD_W-1:0] CMD_MRS = 3'd3;

  typedef struct packed {
    logic              valid;
    logic [CMD_W-1:0]  cmd;
    logic [BANK_W-1:0] bank;
    logic [ADDR_W-1:0] addr;
    logic [WAIT_W-1:0] waitCnt;
  } entry_t;

  localparam int ENTRY_W = $bits(entry_t);

  typedef struct packed {
    logic wrAllow;
    logic startRun;
    logic issue;
    logic decWait;
  } seq_strobe_t;
endpackage

// File: rtl/init_datapath.sv
module init_datapath
  import ddr2_init_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  seq_strobe_t       stb,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [ENTRY_W-1:0] wrData,
  output logic              found,
  output logic              waitZero,
  output logic [CMD_W-1:0]  cmdOut,
  output logic [BANK_W-1:0] bankOut,
  output logic [ADDR_W-1:0] addrOut
);
  entry_t            tbl [NUM_ENTRIES];
  logic [PTR_W-1:0]  ptr;
  logic [WAIT_W-1:0] waitCnt;
  logic [IDX_W-1:0]  hitIdx;
  entry_t            sel;

  // Entry storage; writes only land when the control allows them.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ENTRIES; i++) tbl[i] <= '0;
    end else if (stb.wrAllow && wrEn && (int'(wrIdx) < NUM_ENTRIES)) begin
      tbl[wrIdx] <= entry_t'(wrData);
    end
  end

  // Lowest valid entry at or above the pointer.
  always_comb begin
    found  = 1'b0;
    hitIdx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if ((i >= int'(ptr)) && tbl[i].valid) begin
        found  = 1'b1;
        hitIdx = IDX_W'(i);
      end
    end
  end

  assign sel      = tbl[hitIdx];
  assign waitZero = (waitCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr     <= '0;
      waitCnt <= '0;
    end else if (stb.startRun) begin
      ptr     <= '0;
      waitCnt <= '0;
    end else if (stb.issue) begin
      ptr     <= PTR_W'(hitIdx) + PTR_W'(1);
      waitCnt <= sel.waitCnt;
    end else if (stb.decWait) begin
      waitCnt <= waitCnt - WAIT_W'(1);
    end
  end

  assign cmdOut  = stb.issue ? sel.cmd  : CMD_NOP;
  assign bankOut = stb.issue ? sel.bank : '0;
  assign addrOut = stb.issue ? sel.addr : '0;
endmodule

// File: rtl/init_control.sv
module init_control
  import ddr2_init_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        execReq,
  input  logic        ctrlEnSet,
  input  logic        found,
  input  logic        waitZero,
  output seq_strobe_t stb,
  output logic        busy,
  output logic        initDone,
  output logic        ctrlEnable
);
  logic running;
  logic finish;

  always_comb begin
    stb.wrAllow  = !running;
    stb.startRun = execReq && !running;
    stb.issue    = running && waitZero && found;
    stb.decWait  = running && !waitZero;
  end
  assign finish = running && waitZero && !found;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running    <= 1'b0;
      initDone   <= 1'b0;
      ctrlEnable <= 1'b0;
    end else begin
      if (stb.startRun) begin
        running    <= 1'b1;
        initDone   <= 1'b0;
        ctrlEnable <= 1'b0;
      end else begin
        if (finish) begin
          running  <= 1'b0;
          initDone <= 1'b1;
        end
        if (ctrlEnSet && initDone) ctrlEnable <= 1'b1;
      end
    end
  end

  assign busy = running;
endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [ENTRY_W-1:0] wrData,
  input  logic               execReq,
  input  logic               ctrlEnSet,
  input  logic               calDoneIn,
  output logic               cmdIssue,
  output logic [CMD_W-1:0]   cmdOut,
  output logic [BANK_W-1:0]  bankOut,
  output logic [ADDR_W-1:0]  addrOut,
  output logic               busy,
  output logic               initDone,
  output logic               ctrlEnable,
  output logic               calDoneOut
);
  seq_strobe_t stb;
  logic        found;
  logic        waitZero;

  init_control ctrl_i (
    .clk(clk), .rstN(rstN), .execReq(execReq), .ctrlEnSet(ctrlEnSet),
    .found(found), .waitZero(waitZero), .stb(stb), .busy(busy),
    .initDone(initDone), .ctrlEnable(ctrlEnable)
  );

  init_datapath dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .wrEn(wrEn), .wrIdx(wrIdx),
    .wrData(wrData), .found(found), .waitZero(waitZero), .cmdOut(cmdOut),
    .bankOut(bankOut), .addrOut(addrOut)
  );

  assign cmdIssue   = stb.issue;
  assign calDoneOut = calDoneIn;
endmodule

// File: rtl/ddr2_init_seq_checker.sv
module ddr2_init_seq_checker
  import ddr2_init_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              execReq,
  input logic              cmdIssue,
  input logic [CMD_W-1:0]  cmdOut,
  input logic [BANK_W-1:0] bankOut,
  input logic [ADDR_W-1:0] addrOut,
  input logic              busy,
  input logic              initDone,
  input logic              ctrlEnable
);
  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    (execReq && !busy) |=> busy);

  a_r5_quiet_bus: assert property (@(posedge clk) disable iff (!rstN)
    !cmdIssue |-> (cmdOut == CMD_NOP && bankOut == '0 && addrOut == '0));

  a_r5_issue_in_run: assert property (@(posedge clk) disable iff (!rstN)
    cmdIssue |-> busy);

  a_r6_done_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && initDone));

  a_r7_enable_needs_done: assert property (@(posedge clk) disable iff (!rstN)
    ctrlEnable |-> initDone);
endmodule

bind ddr2_init_seq ddr2_init_seq_checker chk_i (
  .clk(clk), .rstN(rstN), .execReq(execReq), .cmdIssue(cmdIssue),
  .cmdOut(cmdOut), .bankOut(bankOut), .addrOut(addrOut), .busy(busy),
  .initDone(initDone), .ctrlEnable(ctrlEnable)
);

// File: tb/ddr2_init_seq_tb_top.sv
`timescale 1ns/1ps
module ddr2_init_seq_tb_top;
  import ddr2_init_pkg::*;

  typedef struct {
    logic [CMD_W-1:0]  cmd;
    logic [BANK_W-1:0] bank;
    logic [ADDR_W-1:0] addr;
    int                stamp;
    int                idx;
  } exp_t;

  logic clk = 0;
  logic rstN = 0;
  logic wrEn = 0;
  logic [IDX_W-1:0] wrIdx = '0;
  logic [ENTRY_W-1:0] wrData = '0;
  logic execReq = 0, ctrlEnSet = 0, calDoneIn = 0;
  logic cmdIssue, busy, initDone, ctrlEnable, calDoneOut;
  logic [CMD_W-1:0] cmdOut;
  logic [BANK_W-1:0] bankOut;
  logic [ADDR_W-1:0] addrOut;

  int total = 0, bad = 0, cyc = 0;
  exp_t expQ[$];
  logic [ENTRY_W-1:0] model [NUM_ENTRIES];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ddr2_init_seq dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [ENTRY_W-1:0] mk(input bit v, input int c, input int b,
                                            input int a, input int w);
    return {v, CMD_W'(c), BANK_W'(b), ADDR_W'(a), WAIT_W'(w)};
  endfunction

  // R1: write an entry through the port and keep the bench's own model copy.
  task automatic wr(input int idx, input logic [ENTRY_W-1:0] d);
    @(negedge clk);
    wrEn = 1; wrIdx = IDX_W'(idx); wrData = d;
    @(negedge clk);
    wrEn = 0;
    model[idx] = d;
  endtask

  // Starts a run and pushes the expected command stream; returns done stamp.
  task automatic startRun(output int doneAt);
    int stamp;
    int lastW;
    bit any;
    @(negedge clk);
    execReq = 1;
    stamp = cyc + 1;
    any = 0;
    lastW = 0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      entry_t e;
      e = entry_t'(model[i]);
      if (e.valid) begin
        exp_t x;
        if (any) stamp = stamp + lastW + 1;
        x.cmd = e.cmd; x.bank = e.bank; x.addr = e.addr; x.stamp = stamp; x.idx = i;
        expQ.push_back(x);
        lastW = int'(e.waitCnt);
        any = 1;
      end
    end
    doneAt = any ? stamp + lastW + 2 : stamp + 1;
    @(negedge clk);
    execReq = 0;
  endtask

  task automatic waitDone(input int doneAt);
    int guard;
    guard = 0;
    while (!initDone && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    chk(cyc == doneAt, "R6 done timing", cyc, doneAt);
    chk(expQ.size() == 0, "R3 all entries issued", expQ.size(), 0);
    chk(busy == 0, "R6 busy clear at done", int'(busy), 0);
  endtask

  // Monitor: pop and compare every issued command (R3, R4, R5).
  always @(negedge clk) begin
    if (rstN && cmdIssue) begin
      if (expQ.size() == 0) begin
        chk(0, "R8 unexpected command", int'(cmdOut), -1);
      end else begin
        exp_t x;
        x = expQ.pop_front();
        chk(cyc == x.stamp, "R4 issue cycle", cyc, x.stamp);
        chk(cmdOut == x.cmd && bankOut == x.bank && addrOut == x.addr,
            "R5 command fields", int'({cmdOut, bankOut, addrOut}),
            int'({x.cmd, x.bank, x.addr}));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int doneAt;
    int emr;
    int mr;
    for (int i = 0; i < NUM_ENTRIES; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R10 reset state
    chk(busy == 0, "R10 busy", int'(busy), 0);
    chk(initDone == 0, "R10 initDone", int'(initDone), 0);
    chk(ctrlEnable == 0, "R10 ctrlEnable", int'(ctrlEnable), 0);
    chk(cmdIssue == 0 && cmdOut == 0, "R10 bus idle", int'(cmdOut), 0);

    // R7 early enable request ignored
    ctrlEnSet = 1; @(negedge clk); ctrlEnSet = 0; @(negedge clk);
    chk(ctrlEnable == 0, "R7 enable before done", int'(ctrlEnable), 0);

    // Standard DDR2 power-up program (R1, R3, R4)
    emr = 'h044; mr = 'h642;
    wr(0,  mk(1, 0, 0, 0, 106));
    wr(1,  mk(1, 1, 0, 'h400, 4));
    wr(2,  mk(1, 3, 2, 0, 2));
    wr(3,  mk(1, 3, 3, 0, 2));
    wr(4,  mk(1, 3, 1, emr, 2));
    wr(5,  mk(1, 3, 0, mr | 'h100, 200));
    wr(6,  mk(1, 1, 0, 'h400, 4));
    for (int i = 7; i <= 10; i++) wr(i, mk(1, 2, 0, 0, 25));
    wr(11, mk(1, 3, 0, mr, 2));
    wr(12, mk(1, 3, 1, emr | 'h380, 2));
    wr(13, mk(1, 3, 1, emr, 2));

    startRun(doneAt);
    repeat (40) @(negedge clk);
    // R8 interference in mid-run; R7 enable refused during run
    execReq = 1; ctrlEnSet = 1; wrEn = 1; wrIdx = IDX_W'(13);
    wrData = mk(1, 2, 3, 'h1234, 9);
    @(negedge clk);
    execReq = 0; ctrlEnSet = 0; wrEn = 0;
    @(negedge clk);
    chk(ctrlEnable == 0, "R7 enable during run", int'(ctrlEnable), 0);
    chk(busy == 1, "R2 busy during run", int'(busy), 1);
    chk(initDone == 0, "R6 done low in run", int'(initDone), 0);
    waitDone(doneAt);
    ctrlEnSet = 1; @(negedge clk); ctrlEnSet = 0; @(negedge clk);
    chk(ctrlEnable == 1, "R7 enable after done", int'(ctrlEnable), 1);

    // Sparse program: skipped entries and zero waits (R3, R4)
    wr(0,  mk(0, 0, 0, 0, 50));
    wr(2,  mk(1, 2, 0, 0, 0));
    wr(3,  mk(1, 1, 0, 'h400, 0));
    wr(5,  mk(0, 3, 0, 0, 7));
    wr(9,  mk(1, 3, 2, 'h2AA, 3));
    wr(13, mk(0, 3, 1, 0, 1));
    startRun(doneAt);
    chk(ctrlEnable == 0, "R7 cleared by execute", int'(ctrlEnable), 0);
    waitDone(doneAt);

    // All entries invalid (R6)
    for (int i = 0; i < NUM_ENTRIES; i++) wr(i, mk(0, 1, 1, 1, 5));
    startRun(doneAt);
    waitDone(doneAt);

    // R9 passthrough
    calDoneIn = 1; #1;
    chk(calDoneOut == 1, "R9 cal high", int'(calDoneOut), 1);
    calDoneIn = 0; #1;
    chk(calDoneOut == 0, "R9 cal low", int'(calDoneOut), 0);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule